// File: doc/BRIEF.md
# Debug Address Breakpoint Match Unit

This block compares the events of one execution pipeline against four debug breakpoint slots. Each slot has a base address from a plain input bus. A shared 32-bit control word gives each slot two enable bits, a type and a length code. Three kinds of event are checked: instruction fetches, data accesses (address, byte count, direction) and I/O port accesses (port, byte count). For every valid event the block drives a per-slot hit vector in the same cycle.

One cycle after the event, the block produces a registered status field, a one-cycle debug-exception request and a resume address. Status bits are recorded for matching slots even when those slots are disabled. Only an enabled match raises the exception. A flag shows when at least one slot is armed as an I/O breakpoint, so the pipeline can route port accesses through the check.

Top module: `dbg_bp_match`

## Requirements
- R1: Slot i counts as enabled when control bit 2i (local enable) or control bit 2i+1 (global enable) is 1. Either bit alone is enough.
- R2: The type of slot i is control bits [17+4i:16+4i] and its length code is bits [19+4i:18+4i]. The length code gives the slot's byte span: 0 is 1 byte, 1 is 2 bytes, 2 is 8 bytes, 3 is 4 bytes.
- R3: A slot of type 0 (execute) matches a fetch event only when its base address equals the fetch address exactly. Its length code is ignored. Slots of any other type never match a fetch.
- R4: A data event matches a slot of type 1 (data write) only when ev_write_i is 1, and matches a slot of type 3 (data read/write) in either direction. A match needs the byte range [addr, addr+size-1] to overlap [base, base+span-1].
- R5: An I/O event matches only slots that are of type 2 (I/O) and enabled, by the same range overlap rule. Slots of other types and disabled I/O slots never match it.
- R6: ev_kind_i is encoded as 0 fetch, 1 data, 2 I/O, 3 no check. hit_o shows the per-slot match vector in the same cycle as a valid event. For fetch and data events it includes disabled slots. It is 0 for kind 3 or when ev_valid_i is 0.
- R7: After a fetch or data event, status_o takes the full match vector on the next clock edge when any enabled slot matched or force_upd_i was 1. Otherwise status_o keeps its value.
- R8: dbg_req_o is high for exactly the one cycle after an event in two cases: a fetch or data event where an enabled slot matched, or an I/O event with any match. It is low otherwise.
- R9: With dbg_req_o, resume_ip_o shows the fetch address for a fetch event and next_ip_i for a data or I/O event. After an I/O hit, status_o equals the I/O hit vector.
- R10: io_armed_o is high whenever some slot has type 2 and is enabled.
- R11: While rst_ni is low, status_o, dbg_req_o and resume_ip_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 32 | Shared breakpoint control word |
| slot_addr_i | input | NUM_SLOTS*ADDR_W | Slot base addresses, slot i at bits [ADDR_W*i +: ADDR_W] |
| ev_valid_i | input | 1 | Event present this cycle |
| ev_kind_i | input | 2 | Event kind: 0 fetch, 1 data, 2 I/O, 3 none |
| ev_addr_i | input | ADDR_W | Fetch address, data address or port number |
| ev_size_i | input | SIZE_W | Access size in bytes (0 treated as 1) |
| ev_write_i | input | 1 | Data access is a write |
| force_upd_i | input | 1 | Record the status for a fetch or data event even without an enabled hit |
| next_ip_i | input | ADDR_W | Address of the following instruction |
| hit_o | output | NUM_SLOTS | Per-slot match vector, combinational |
| io_armed_o | output | 1 | At least one enabled I/O slot |
| status_o | output | NUM_SLOTS | Registered per-slot status bits |
| dbg_req_o | output | 1 | Debug exception request, one-cycle pulse |
| resume_ip_o | output | ADDR_W | Resume address reported with the request |

## Verification
hit_o and io_armed_o are combinational. The bench sets the event inputs at a falling edge and reads them 1 ns later, before any rising edge. status_o, dbg_req_o and resume_ip_o change at the first rising edge after the event. They are read 1 ns after that edge, which is the only cycle in which the request pulse is visible. Valid is then dropped, so each event occupies exactly one clock edge. The bench keeps the expected status from one event to the next, so it also catches a status update that should not have happened.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;

  typedef enum logic [1:0] {
    BP_EXEC = 2'd0,
    BP_DWR  = 2'd1,
    BP_IO   = 2'd2,
    BP_DRW  = 2'd3
  } bp_type_e;

  typedef enum logic [1:0] {
    EV_FETCH = 2'd0,
    EV_DATA  = 2'd1,
    EV_IO    = 2'd2,
    EV_NONE  = 2'd3
  } ev_kind_e;

  localparam int TYPE_BASE   = 16;
  localparam int LEN_BASE    = 18;
  localparam int SLOT_STRIDE = 4;

  // non-linear span code
  function automatic logic [3:0] span_bytes(input logic [1:0] code);
    case (code)
      2'd0:    span_bytes = 4'd1;
      2'd1:    span_bytes = 4'd2;
      2'd2:    span_bytes = 4'd8;
      default: span_bytes = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot
  import dbg_bp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        en_bits_i,
  input  logic [1:0]        type_i,
  input  logic [1:0]        len_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              ev_valid_i,
  input  ev_kind_e          ev_kind_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  input  logic [SIZE_W-1:0] ev_size_i,
  input  logic              ev_write_i,
  output logic              en_o,
  output logic              match_o,
  output logic              io_arm_o
);

  localparam int EXT_W = ADDR_W + 1;

  bp_type_e          ty;
  logic [3:0]        span;
  logic [SIZE_W-1:0] sz_eff;
  logic [EXT_W-1:0]  slot_lo, slot_hi, ev_lo, ev_hi;
  logic              overlap;
  logic              hit;

  assign ty       = bp_type_e'(type_i);
  assign span     = span_bytes(len_i);
  assign en_o     = |en_bits_i;
  assign io_arm_o = en_o && (ty == BP_IO);

  // extra bit keeps range ends from wrapping
  assign sz_eff  = (ev_size_i == '0) ? SIZE_W'(1) : ev_size_i;
  assign slot_lo = {1'b0, base_i};
  assign slot_hi = slot_lo + EXT_W'(span) - EXT_W'(1);
  assign ev_lo   = {1'b0, ev_addr_i};
  assign ev_hi   = ev_lo + EXT_W'(sz_eff) - EXT_W'(1);
  assign overlap = (ev_hi >= slot_lo) && (ev_lo <= slot_hi);

  always_comb begin
    hit = 1'b0;
    unique case (ev_kind_i)
      EV_FETCH: hit = (ty == BP_EXEC) && (ev_addr_i == base_i);
      EV_DATA:  hit = overlap && ((ty == BP_DRW) || ((ty == BP_DWR) && ev_write_i));
      EV_IO:    hit = overlap && (ty == BP_IO) && en_o;
      default:  hit = 1'b0;
    endcase
  end

  assign match_o = ev_valid_i && hit;

  assert_wr_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_kind_i == EV_DATA && !ev_write_i && type_i == 2'd1) |-> !match_o);

  assert_io_enabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_kind_i == EV_IO && match_o) |-> io_arm_o);

endmodule

// File: rtl/dbg_bp_status.sv
module dbg_bp_status
  import dbg_bp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ev_valid_i,
  input  ev_kind_e             ev_kind_i,
  input  logic [NUM_SLOTS-1:0] match_i,
  input  logic [NUM_SLOTS-1:0] en_i,
  input  logic                 force_i,
  input  logic [ADDR_W-1:0]    ev_addr_i,
  input  logic [ADDR_W-1:0]    next_ip_i,
  output logic [NUM_SLOTS-1:0] status_o,
  output logic                 req_o,
  output logic [ADDR_W-1:0]    resume_o
);

  logic                 en_hit;
  logic                 upd, raise;
  logic [ADDR_W-1:0]    res_addr;
  logic [NUM_SLOTS-1:0] status_q;
  logic                 req_q;
  logic [ADDR_W-1:0]    resume_q;

  assign en_hit = |(match_i & en_i);

  always_comb begin
    upd      = 1'b0;
    raise    = 1'b0;
    res_addr = next_ip_i;
    if (ev_valid_i) begin
      unique case (ev_kind_i)
        EV_FETCH: begin
          upd      = en_hit || force_i;
          raise    = en_hit;
          res_addr = ev_addr_i;
        end
        EV_DATA: begin
          upd   = en_hit || force_i;
          raise = en_hit;
        end
        EV_IO: begin
          // io matches are already gated by enable
          upd   = |match_i;
          raise = |match_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      req_q    <= 1'b0;
      resume_q <= '0;
    end else begin
      if (upd)   status_q <= match_i;
      req_q <= raise;
      if (raise) resume_q <= res_addr;
    end
  end

  assign status_o = status_q;
  assign req_o    = req_q;
  assign resume_o = resume_q;

  assert_req_has_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (status_o != '0));

  assert_req_after_event_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(ev_valid_i));

  assert_status_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_valid_i |=> $stable(status_o));

endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
  import dbg_bp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 4,
  parameter int CTRL_W    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [CTRL_W-1:0]           ctrl_i,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_i,
  input  logic                        ev_valid_i,
  input  logic [1:0]                  ev_kind_i,
  input  logic [ADDR_W-1:0]           ev_addr_i,
  input  logic [SIZE_W-1:0]           ev_size_i,
  input  logic                        ev_write_i,
  input  logic                        force_upd_i,
  input  logic [ADDR_W-1:0]           next_ip_i,
  output logic [NUM_SLOTS-1:0]        hit_o,
  output logic                        io_armed_o,
  output logic [NUM_SLOTS-1:0]        status_o,
  output logic                        dbg_req_o,
  output logic [ADDR_W-1:0]           resume_ip_o
);

  ev_kind_e             kind;
  logic [NUM_SLOTS-1:0] slot_en, slot_match, slot_io;

  assign kind = ev_kind_e'(ev_kind_i);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam int TY_LSB = TYPE_BASE + SLOT_STRIDE * i;
    localparam int LN_LSB = LEN_BASE + SLOT_STRIDE * i;

    dbg_bp_slot #(
      .ADDR_W (ADDR_W),
      .SIZE_W (SIZE_W)
    ) i_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_bits_i  (ctrl_i[2*i +: 2]),
      .type_i     (ctrl_i[TY_LSB +: 2]),
      .len_i      (ctrl_i[LN_LSB +: 2]),
      .base_i     (slot_addr_i[ADDR_W*i +: ADDR_W]),
      .ev_valid_i (ev_valid_i),
      .ev_kind_i  (kind),
      .ev_addr_i  (ev_addr_i),
      .ev_size_i  (ev_size_i),
      .ev_write_i (ev_write_i),
      .en_o       (slot_en[i]),
      .match_o    (slot_match[i]),
      .io_arm_o   (slot_io[i])
    );
  end

  dbg_bp_status #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W)
  ) i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_valid_i (ev_valid_i),
    .ev_kind_i  (kind),
    .match_i    (slot_match),
    .en_i       (slot_en),
    .force_i    (force_upd_i),
    .ev_addr_i  (ev_addr_i),
    .next_ip_i  (next_ip_i),
    .status_o   (status_o),
    .req_o      (dbg_req_o),
    .resume_o   (resume_ip_o)
  );

  assign hit_o      = slot_match;
  assign io_armed_o = |slot_io;

  assert_io_hit_armed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && kind == EV_IO && hit_o != '0) |-> io_armed_o);

  assert_idle_no_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_valid_i || kind == EV_NONE) |-> (hit_o == '0));

endmodule

// File: tb/test_dbg_bp_match.sv
module test_dbg_bp_match;

  localparam int N = 4;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   ctrl = '0;
  logic [AW-1:0] a0 = 32'h1000, a1 = 32'h2000, a2 = 32'h60, a3 = 32'h3004;
  logic          ev_valid = 1'b0;
  logic [1:0]    ev_kind = 2'd3;
  logic [AW-1:0] ev_addr = '0;
  logic [3:0]    ev_size = 4'd1;
  logic          ev_write = 1'b0;
  logic          force_upd = 1'b0;
  logic [AW-1:0] next_ip = 32'h9000_0000;
  logic [N-1:0]  hit, status;
  logic          io_armed, dbg_req;
  logic [AW-1:0] resume_ip;

  int n_tests = 0;
  int n_fail = 0;
  logic [N-1:0] exp_st = '0;

  always #4 clk = ~clk;

  dbg_bp_match i_dbg_bp_match (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctrl_i      (ctrl),
    .slot_addr_i ({a3, a2, a1, a0}),
    .ev_valid_i  (ev_valid),
    .ev_kind_i   (ev_kind),
    .ev_addr_i   (ev_addr),
    .ev_size_i   (ev_size),
    .ev_write_i  (ev_write),
    .force_upd_i (force_upd),
    .next_ip_i   (next_ip),
    .hit_o       (hit),
    .io_armed_o  (io_armed),
    .status_o    (status),
    .dbg_req_o   (dbg_req),
    .resume_ip_o (resume_ip)
  );

  function automatic logic [31:0] fld(int s, logic [1:0] en, logic [1:0] ty, logic [1:0] ln);
    logic [31:0] r = '0;
    r[2*s +: 2]    = en;
    r[16+4*s +: 2] = ty;
    r[18+4*s +: 2] = ln;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one event; upd says whether status must take the hit vector
  task automatic ev(string tag, logic [1:0] kind, logic [AW-1:0] addr, logic [3:0] sz,
                    logic wr, logic frc, logic [N-1:0] e_hit, logic e_req, logic upd,
                    logic [AW-1:0] e_res);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = kind; ev_addr = addr; ev_size = sz;
    ev_write = wr; force_upd = frc; next_ip = next_ip + 32'h10;
    #1;
    chk({tag, " hit"}, 32'(hit), 32'(e_hit));
    @(posedge clk);
    #1;
    if (upd) exp_st = e_hit;
    chk({tag, " req"}, 32'(dbg_req), 32'(e_req));
    chk({tag, " status"}, 32'(status), 32'(exp_st));
    if (e_req) chk({tag, " resume"}, resume_ip, e_res);
    ev_valid = 1'b0; force_upd = 1'b0; ev_kind = 2'd3;
  endtask

  task automatic t_reset;
    #1;
    chk("R11 status", 32'(status), 0);
    chk("R11 req", 32'(dbg_req), 0);
    chk("R11 resume", resume_ip, 0);
    chk("R10 armed idle", 32'(io_armed), 0);
  endtask

  task automatic t_exec;
    ctrl = fld(0, 2'b00, 2'd0, 2'd0);
    ev("R7 disabled exec no update", 0, 32'h1000, 1, 0, 0, 4'b0001, 0, 0, 0);
    ev("R7 force records disabled", 0, 32'h1000, 1, 0, 1, 4'b0001, 0, 1, 0);
    ev("R7 force clears on miss", 0, 32'h1004, 1, 0, 1, 4'b0000, 0, 1, 0);
    ctrl = fld(0, 2'b01, 2'd0, 2'd0);
    ev("R1 R3 R9 local exec hit", 0, 32'h1000, 1, 0, 0, 4'b0001, 1, 1, 32'h1000);
    ev("R3 exact only", 0, 32'h1001, 1, 0, 0, 4'b0000, 0, 0, 0);
    ctrl = fld(0, 2'b10, 2'd0, 2'd3);
    ev("R3 length ignored", 0, 32'h1002, 1, 0, 0, 4'b0000, 0, 0, 0);
    ev("R1 global exec hit", 0, 32'h1000, 1, 0, 0, 4'b0001, 1, 1, 32'h1000);
  endtask

  task automatic t_multi;
    a3 = 32'h1000;
    ctrl = fld(0, 2'b01, 2'd0, 2'd0) | fld(3, 2'b00, 2'd0, 2'd0);
    ev("R6 R7 disabled slot in status", 0, 32'h1000, 1, 0, 0, 4'b1001, 1, 1, 32'h1000);
    a3 = 32'h3004;
  endtask

  task automatic t_data;
    ctrl = fld(1, 2'b01, 2'd1, 2'd3);
    ev("R4 write-only ignores read", 1, 32'h2002, 1, 0, 0, 4'b0000, 0, 0, 0);
    ev("R4 R9 write hit", 1, 32'h2003, 2, 1, 0, 4'b0010, 1, 1, next_ip + 32'h10);
    ev("R2 span4 end", 1, 32'h2004, 1, 1, 0, 4'b0000, 0, 0, 0);
    ev("R4 below miss", 1, 32'h1FFE, 2, 1, 0, 4'b0000, 0, 0, 0);
    ev("R4 overlap from below", 1, 32'h1FFE, 4, 1, 0, 4'b0010, 1, 1, next_ip + 32'h10);
    ctrl = fld(1, 2'b01, 2'd3, 2'd2);
    ev("R2 R4 span8 read hit", 1, 32'h2007, 1, 0, 0, 4'b0010, 1, 1, next_ip + 32'h10);
    ev("R2 span8 end", 1, 32'h2008, 1, 0, 0, 4'b0000, 0, 0, 0);
    ctrl = fld(1, 2'b01, 2'd3, 2'd1);
    ev("R2 span2 hit", 1, 32'h2001, 1, 0, 0, 4'b0010, 1, 1, next_ip + 32'h10);
    ev("R2 span2 end", 1, 32'h2002, 1, 0, 0, 4'b0000, 0, 0, 0);
    ctrl = fld(1, 2'b01, 2'd3, 2'd0);
    ev("R2 span1 hit", 1, 32'h2000, 1, 1, 0, 4'b0010, 1, 1, next_ip + 32'h10);
    ev("R2 span1 end", 1, 32'h2001, 1, 1, 0, 4'b0000, 0, 0, 0);
  endtask

  task automatic t_io;
    ctrl = fld(2, 2'b01, 2'd2, 2'd1) | fld(0, 2'b01, 2'd0, 2'd0);
    #1;
    chk("R10 armed", 32'(io_armed), 1);
    ev("R5 R9 io hit", 2, 32'h61, 1, 0, 0, 4'b0100, 1, 1, next_ip + 32'h10);
    ev("R5 io overlap below", 2, 32'h5F, 2, 0, 0, 4'b0100, 1, 1, next_ip + 32'h10);
    ev("R5 io miss", 2, 32'h62, 1, 0, 0, 4'b0000, 0, 0, 0);
    ev("R5 exec slot ignores io", 2, 32'h1000, 1, 0, 0, 4'b0000, 0, 0, 0);
    ev("R3 io slot ignores fetch", 0, 32'h60, 1, 0, 0, 4'b0000, 0, 0, 0);
    ctrl = fld(2, 2'b00, 2'd2, 2'd1);
    #1;
    chk("R10 disarmed", 32'(io_armed), 0);
    ev("R5 disabled io slot", 2, 32'h60, 1, 0, 0, 4'b0000, 0, 0, 0);
  endtask

  task automatic t_none;
    ctrl = fld(0, 2'b01, 2'd0, 2'd0);
    ev("R6 kind none", 3, 32'h1000, 1, 0, 1, 4'b0000, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #20;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_exec();
    t_multi();
    t_data();
    t_io();
    t_none();
    @(negedge clk);
    chk("R8 single pulse", 32'(dbg_req), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule